// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit binary32 operands together with a valid strobe and returns their product two clock cycles later. The result sign is the XOR of the operand signs. The biased exponents are added and the bias of 127 is removed. The 24-bit significands, with the hidden one restored, are multiplied into a 48-bit product. The product is then normalized and truncated to 24 bits and packed into a binary32 word. An operand whose exponent field is zero counts as zero, and the product is then a zero.

An exponent that leaves the normal range is replaced by a fixed encoding, and one of two flags marks it. Overflow gives an infinity with the result's sign. Underflow gives a zero with the result's sign. NaN handling, round-to-nearest and denormal operands are not provided. Every field of the exponent-255 encoding is multiplied as an ordinary number.

A parameter selects how the significand product is built. The default is a radix-4 Booth partial-product array; the other choice is a direct multiply. Both give the same 48-bit product. The pipeline takes one operation per cycle with no stalls.

Top module: `fpmul_top`

## Requirements
- R1: While reset is held and after reset releases, out_valid, out_ovf and out_unf are 0 and out_result is 0x00000000 until the first accepted operation emerges.
- R2: If either operand has an exponent field (bits 30:23) of zero, the result is a zero whose sign (bit 31) is the XOR of the operand signs, and both flags stay 0.
- R3: The 23-bit result fraction is the 48-bit significand product with its low product bits discarded, with no rounding.
- R4: The result sign bit 31 is the XOR of the two input bit-31 values. For non-zero operands, the result exponent field is Ea + Eb - 127 before normalization.
- R5: When product bit 47 is 1, the result exponent is incremented by one and the fraction is product bits 46:24. Otherwise the fraction is bits 45:23.
- R6: If the biased exponent after the normalization increment is 255 or more, the result is sign, exponent field 0xFF, fraction 0, and out_ovf is 1 (out_unf 0).
- R7: If the biased exponent after normalization is 0 or less, the result is sign, exponent 0, fraction 0, and out_unf is 1 (out_ovf 0).
- R8: out_valid is 1 exactly two cycles after each cycle with in_valid 1, and 0 otherwise. Back-to-back operations are accepted every cycle. Both flags are 0 whenever out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | out_result and flags hold a product |
| out_result | output | 32 | Packed binary32 product |
| out_ovf | output | 1 | Exponent overflow, result is signed infinity |
| out_unf | output | 1 | Exponent underflow, result is signed zero |

## Verification
The normalization increment and the range check act on the same exponent in the same cycle. The bench provokes this with operand pairs whose exponent sum lands on the boundary. A sum of 254 with significands of 1.5 gives a product of 2.25, which must overflow only because of the increment. A sum of 0 with the same significands must escape underflow. Each such pair is placed next to a twin whose product stays below 2, so the two outcomes differ by one exponent step. Every result and flag is compared against a behavioural model that uses integer arithmetic, both on these pairs and on a long back-to-back random stream with bubbles.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
  // Variant of the significand product unit
  typedef enum logic {
    MUL_DIRECT = 1'b0,
    MUL_BOOTH4 = 1'b1
  } mul_style_e;

  // Exception flags leaving the pack stage
  typedef struct packed {
    logic ovf;
    logic unf;
  } fpm_flags_t;
endpackage

// File: rtl/fpm_unpack.sv
`timescale 1ns/1ps
module fpm_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      expo,
  output logic [FRAC_W:0]       man,
  output logic                  is_zero
);
  assign sign    = word[EXP_W+FRAC_W];
  assign expo    = word[EXP_W+FRAC_W-1:FRAC_W];
  // zero exponent field counts as zero (denormals out of scope)
  assign is_zero = (expo == '0);
  assign man     = {1'b1, word[FRAC_W-1:0]};
endmodule

// File: rtl/fpm_mant_mul.sv
`timescale 1ns/1ps
module fpm_mant_mul
  import fpm_pkg::*;
#(
  parameter int         MAN_W = 24,
  parameter mul_style_e STYLE = MUL_BOOTH4
) (
  input  logic [MAN_W-1:0]   x,
  input  logic [MAN_W-1:0]   y,
  output logic [2*MAN_W-1:0] prod
);
  localparam int PROD_W = 2 * MAN_W;

  generate
    if (STYLE == MUL_DIRECT) begin : g_direct
      assign prod = PROD_W'(x) * PROD_W'(y);
    end else begin : g_booth
      localparam int NPP  = (MAN_W + 2) / 2;
      localparam int YX_W = 2 * NPP + 1;
      localparam int PPW  = PROD_W + 4;

      // one radix-4 partial product, modulo 2^PPW
      function automatic logic [PPW-1:0] pp_of(input logic [2:0] t,
                                               input logic [MAN_W-1:0] m);
        logic [PPW-1:0] mag;
        mag = {{(PPW-MAN_W){1'b0}}, m};
        case (t)
          3'b001, 3'b010: pp_of = mag;
          3'b011:         pp_of = mag << 1;
          3'b100:         pp_of = -(mag << 1);
          3'b101, 3'b110: pp_of = -mag;
          default:        pp_of = '0;
        endcase
      endfunction

      logic [YX_W-1:0]           yx;
      logic [NPP-1:0][PPW-1:0]   pp;
      logic [PPW-1:0]            acc;

      assign yx = {{(YX_W-MAN_W-1){1'b0}}, y, 1'b0};

      for (genvar gi = 0; gi < NPP; gi++) begin : g_pp
        assign pp[gi] = pp_of(yx[2*gi+2 -: 3], x) << (2 * gi);
      end

      always_comb begin
        acc = '0;
        for (int i = 0; i < NPP; i++) acc = acc + pp[i];
      end

      assign prod = acc[PROD_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fpm_norm_pack.sv
`timescale 1ns/1ps
module fpm_norm_pack
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                       sign,
  input  logic                       zero,
  input  logic signed [EXP_W+1:0]    exp_sum,
  input  logic [2*FRAC_W+1:0]        prod,
  output logic [EXP_W+FRAC_W:0]      result,
  output fpm_flags_t                 flags,
  output logic                       norm_shift,
  output logic signed [EXP_W+1:0]    exp_adj
);
  localparam int PROD_W = 2 * (FRAC_W + 1);
  localparam int EXPI_W = EXP_W + 2;
  localparam logic signed [EXPI_W-1:0] EXP_TOP = EXPI_W'((1 << EXP_W) - 1);
  localparam logic signed [EXPI_W-1:0] EXP_NIL = '0;

  logic [FRAC_W-1:0] frac;

  assign norm_shift = prod[PROD_W-1];
  assign exp_adj    = exp_sum + EXPI_W'(norm_shift);
  assign frac       = norm_shift ? prod[PROD_W-2 -: FRAC_W]
                                 : prod[PROD_W-3 -: FRAC_W];

  assign flags.ovf = !zero && (exp_adj >= EXP_TOP);
  assign flags.unf = !zero && (exp_adj <= EXP_NIL);

  always_comb begin
    if (zero || flags.unf)
      result = {sign, {(EXP_W+FRAC_W){1'b0}}};
    else if (flags.ovf)
      result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      result = {sign, exp_adj[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fpmul_top.sv
`timescale 1ns/1ps
module fpmul_top
  import fpm_pkg::*;
#(
  parameter int         EXP_W     = 8,
  parameter int         FRAC_W    = 23,
  parameter mul_style_e MUL_STYLE = MUL_BOOTH4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [EXP_W+FRAC_W:0]    op_a,
  input  logic [EXP_W+FRAC_W:0]    op_b,
  output logic                     out_valid,
  output logic [EXP_W+FRAC_W:0]    out_result,
  output logic                     out_ovf,
  output logic                     out_unf
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int MAN_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * MAN_W;
  localparam int EXPI_W = EXP_W + 2;
  localparam logic signed [EXPI_W-1:0] BIAS_S = EXPI_W'((1 << (EXP_W - 1)) - 1);

  // operand decode
  logic             sa, sb, za, zb;
  logic [EXP_W-1:0] ea, eb;
  logic [MAN_W-1:0] ma, mb;

  fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
    .word(op_a), .sign(sa), .expo(ea), .man(ma), .is_zero(za));
  fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
    .word(op_b), .sign(sb), .expo(eb), .man(mb), .is_zero(zb));

  logic [PROD_W-1:0] prod_w;
  fpm_mant_mul #(.MAN_W(MAN_W), .STYLE(MUL_STYLE)) u_mul (
    .x(ma), .y(mb), .prod(prod_w));

  // events brought out for the checker
  logic                     zero_op;
  logic signed [EXPI_W-1:0] exp_sum_w;
  assign zero_op   = za || zb;
  assign exp_sum_w = $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS_S;

  // stage A: product and exponent sum
  logic                     a_vld, a_sign, a_zero;
  logic signed [EXPI_W-1:0] a_exp;
  logic [PROD_W-1:0]        a_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld  <= 1'b0;
      a_sign <= 1'b0;
      a_zero <= 1'b0;
      a_exp  <= '0;
      a_prod <= '0;
    end else begin
      a_vld <= in_valid;
      if (in_valid) begin
        a_sign <= sa ^ sb;
        a_zero <= zero_op;
        a_exp  <= exp_sum_w;
        a_prod <= prod_w;
      end
    end
  end

  // stage B: normalize, range check, pack
  logic [WORD_W-1:0]        pk_result;
  fpm_flags_t               pk_flags;
  logic                     norm_shift;
  logic signed [EXPI_W-1:0] exp_adj;

  fpm_norm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .sign(a_sign), .zero(a_zero), .exp_sum(a_exp), .prod(a_prod),
    .result(pk_result), .flags(pk_flags), .norm_shift(norm_shift),
    .exp_adj(exp_adj));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
      out_unf    <= 1'b0;
    end else begin
      out_valid <= a_vld;
      out_ovf   <= a_vld && pk_flags.ovf;
      out_unf   <= a_vld && pk_flags.unf;
      if (a_vld) out_result <= pk_result;
    end
  end
endmodule

// File: rtl/fpmul_chk.sv
`timescale 1ns/1ps
module fpmul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  zero_op,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] out_result,
  input logic                  out_ovf,
  input logic                  out_unf
);
  localparam int W = EXP_W + FRAC_W + 1;

  // cycles since reset, saturating at 2
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_ovf && !out_unf)); // R8
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R8
  AST_OVF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> ((out_result[W-2:FRAC_W] == '1) &&
                                (out_result[FRAC_W-1:0] == '0))); // R6
  AST_UNF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unf) |-> (out_result[W-2:0] == '0)); // R7
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_ovf && out_unf)); // R6
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && out_valid) |->
      (out_result[W-1] == $past(op_a[W-1] ^ op_b[W-1], 2))); // R4
  AST_ZERO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && out_valid && $past(zero_op, 2)) |->
      ((out_result[W-2:0] == '0) && !out_ovf && !out_unf)); // R2
endmodule

bind fpmul_top fpmul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .zero_op(zero_op), .out_valid(out_valid), .out_result(out_result),
  .out_ovf(out_ovf), .out_unf(out_unf));

// File: tb/fpmul_top_tb.sv
`timescale 1ns/1ps
module fpmul_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid, out_ovf, out_unf;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fpmul_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_result(out_result),
    .out_ovf(out_ovf), .out_unf(out_unf));

  typedef struct {
    bit          v;
    logic [31:0] r;
    bit          o;
    bit          u;
    string       tag;
  } exp_t;

  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // behavioural reference, integer arithmetic
  function automatic exp_t model(input bit v, input logic [31:0] a,
                                 input logic [31:0] b);
    exp_t   e;
    int     ea, eb, ex;
    longint pa, pb, p;
    bit     s, hi;
    e.v = v; e.o = 0; e.u = 0;
    s  = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if (ea == 0 || eb == 0) begin
      e.r = {s, 31'd0}; e.tag = "R2"; return e;
    end
    pa = longint'({1'b1, a[22:0]});
    pb = longint'({1'b1, b[22:0]});
    p  = pa * pb;
    hi = p[47];
    ex = ea + eb - 127 + (hi ? 1 : 0);
    if (ex >= 255) begin
      e.r = {s, 8'hFF, 23'd0}; e.o = 1; e.tag = "R6";
    end else if (ex <= 0) begin
      e.r = {s, 31'd0}; e.u = 1; e.tag = "R7";
    end else begin
      e.r = {s, 8'(ex), hi ? p[46:24] : p[45:23]};
      e.tag = hi ? "R5" : "R3";
    end
    return e;
  endfunction

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    in_valid = v; op_a = a; op_b = b;
    q.push_back(model(v, a, b));
    @(negedge clk);
    if (q.size() >= 2) begin
      e = q.pop_front();
      chk(out_valid == e.v, "R8", "out_valid", 32'(out_valid), 32'(e.v));
      if (e.v) begin
        chk(out_result == e.r, e.tag, "result", out_result, e.r);
        chk(out_result[31] == e.r[31], "R4", "sign", 32'(out_result[31]), 32'(e.r[31]));
        chk(out_ovf == e.o, e.tag, "ovf", 32'(out_ovf), 32'(e.o));
        chk(out_unf == e.u, e.tag, "unf", 32'(out_unf), 32'(e.u));
      end else begin
        chk(!out_ovf && !out_unf, "R8", "flags idle", {30'd0, out_ovf, out_unf}, 32'd0);
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1", "out_valid in reset", 32'(out_valid), 0);
    chk(out_result == 0, "R1", "result in reset", out_result, 0);
    chk(!out_ovf && !out_unf, "R1", "flags in reset", {30'd0, out_ovf, out_unf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && out_result == 0, "R1", "after release", out_result, 0);

    step(1, 32'h45129200, 32'h3F400000); // R4 general product
    step(1, 32'h3FC00000, 32'h3FC00000); // R5 product >= 2
    step(1, 32'hC0000000, 32'h40400000); // R4 negative sign
    step(1, 32'h00000000, 32'h40400000); // R2 zero a
    step(1, 32'h3F800000, 32'h80000000); // R2 negative zero b
    step(1, 32'h7F000000, 32'h00000000); // R2 zero beats overflow
    step(1, 32'h7F000000, 32'h7F000000); // R6 plain overflow
    step(1, 32'h3FC00000, 32'h7F400000); // R6 overflow only by increment
    step(1, 32'h3F800000, 32'h7F7FFFFF); // R6 boundary 254 stays normal
    step(1, 32'h00800000, 32'h00800000); // R7 deep underflow
    step(1, 32'h00800000, 32'h3F000000); // R7 exponent exactly 0
    step(1, 32'h80C00000, 32'h3F400000); // R7 escaped by increment
    step(1, 32'h00800000, 32'h3F800000); // R7 boundary 1 normal
    step(1, 32'h3FFFFFFF, 32'h3FFFFFFF); // R3 truncation of all ones
    step(1, 32'h3FAAAAAB, 32'hBFD55555); // R3 truncation mixed
    step(0, 32'h3F800000, 32'h3F800000); // R8 bubble
    step(0, 32'h0, 32'h0);
    for (int i = 0; i < 3000; i++) begin
      bit v;
      v = ($urandom % 5) != 0;
      step(v, $urandom, $urandom);
    end
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = {1'($urandom), 8'(60 + $urandom % 140), 23'($urandom)};
      b = {1'($urandom), 8'(60 + $urandom % 140), 23'($urandom)};
      step(1, a, b); // back-to-back in-range stream
    end
    step(0, 0, 0);
    step(0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule